// File: doc/BRIEF.md
# Byte-Serial Peripheral Link Controller with Sticky Status

This block is a serial peripheral interface engine that moves one byte at a time, either as the clock-driving master or as a clocked slave. Software reaches it through a byte-wide register bus with two locations. Location 0 is the data port: a write fills the single transmit buffer and a read returns the single receive buffer. Location 1 is the control/status byte. Clock polarity is idle-low. Data is captured on the rising edge and shifted on the falling edge, most significant bit first.

The control byte holds the enable bit, a two-bit slave-select mode and four sticky event flags. The flags report a finished byte, a data write that hit a full buffer, a master collision on the select line, and a slave byte lost because the receive buffer was still unread. Hardware only sets these flags, and only software can clear them. The interrupt line is a gated OR of the four flags.

Master operation is requested by a level input. It takes effect only while the block is enabled and no mode fault is pending. A mode fault therefore drops the block out of master mode and releases the clock and data drivers until software clears the flag.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset the control byte reads 0x06. This means mode field (bits 3:2) = 01, transmit-empty (bit 1) = 1, and all flags (bits 7:4) and enable (bit 0) = 0. In this state irq and sclk_oe are low.
- R2: As enabled master, a byte placed in the transmit buffer is sent MSB first on mosi_out with sclk_out idling low. The byte sampled on miso_in at the rising edges is stored in the receive buffer, which is read back at address 0. Bit 7 (done flag) is then set.
- R3: A data write at address 0 while bit 1 is 1 stores the byte and clears bit 1. Bit 1 returns to 1 once the byte is loaded into the shift register, and loading happens only while enable is 1.
- R4: A data write while bit 1 is 0 sets bit 6 (collision flag), and the written byte is discarded: the byte later sent is the earlier one.
- R5: With master_req = 1, enable = 1 and mode 01, a low level on ss_in sets bit 5 (mode fault). While bit 5 is set, sclk_oe and mosi_oe stay low.
- R6: In slave mode, a byte completed while an unread byte sits in the receive buffer sets bit 4 (overrun), and the older byte is kept. In master mode a second byte overwrites the first with no overrun.
- R7: Writing 0 to a flag bit at address 1 clears it, and writing 1 leaves it unchanged. Bit 1 ignores writes.
- R8: irq is high exactly when irq_enable is high and at least one of bits 7:4 is set.
- R9: With enable = 1 and mode bit 3 = 1, ss_oe is high and ss_out equals mode bit 2. Otherwise ss_oe is low.
- R10: As slave, mode 00 receives with ss_in ignored. Mode 01 receives only while ss_in is low, and clock edges with ss_in high complete no byte.
- R11: Clearing enable stops a transfer in progress and drops sclk_oe at once. No done flag is raised for the aborted byte, and flags already set keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = data port, 1 = control/status byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| master_req | input | 1 | Request master operation |
| irq_enable | input | 1 | Interrupt gate |
| irq | output | 1 | Combined interrupt |
| sclk_in | input | 1 | Serial clock from remote master |
| sclk_out | output | 1 | Serial clock driven as master |
| sclk_oe | output | 1 | Serial clock driver enable |
| mosi_in | input | 1 | Slave data input |
| mosi_out | output | 1 | Master data output |
| mosi_oe | output | 1 | Master data driver enable |
| miso_in | input | 1 | Master data input |
| miso_out | output | 1 | Slave data output |
| miso_oe | output | 1 | Slave data driver enable |
| ss_in | input | 1 | Select input, active low |
| ss_out | output | 1 | Select output in single-master modes |
| ss_oe | output | 1 | Select output enable |

## Verification
Master transfers run in loopback with two byte values whose bit patterns differ in every position (0xA5, 0x5A), plus 0x11. A bit-order or capture-edge error therefore shows up as a wrong received byte. Slave transfers drive 0x96, 0x3C, 0xE7 and 0xE1 through both select modes. These show whether the select line is honoured or ignored, and whether the first or the newer byte survives an overrun. Collision, fault, abort and flag-clear sequences are each followed by a control-byte read. A reference model of enable and mode compares the select and clock drivers on every clock.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int BUS_W = 8;

  localparam int B_DONE = 7;
  localparam int B_WCOL = 6;
  localparam int B_FAULT = 5;
  localparam int B_OVR = 4;
  localparam int B_TXE = 1;
  localparam int B_EN = 0;

  typedef enum logic [1:0] {
    SS_3WIRE   = 2'b00,
    SS_4W_IN   = 2'b01,
    SS_DRV_LO  = 2'b10,
    SS_DRV_HI  = 2'b11
  } ss_mode_e;

  localparam logic [BUS_W-1:0] CTRL_RESET = 8'h06;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= RST_VAL;
          else     pipe[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= RST_VAL;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 8,
  parameter int HALF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          is_master,
  input  logic          slv_sel,
  input  logic          sclk_s,
  input  logic          mosi_s,
  input  logic          miso_s,
  input  logic          load_req,
  input  logic [DW-1:0] load_data,
  output logic          load_ack,
  output logic          done,
  output logic [DW-1:0] rx_byte,
  output logic          sclk_o,
  output logic          shift_msb
);
  localparam int CW  = (DW > 2) ? $clog2(DW) : 1;
  localparam int HCW = (HALF > 2) ? $clog2(HALF) : 1;

  logic [DW-1:0]  shreg;
  logic [CW-1:0]  bcnt;
  logic [HCW-1:0] hcnt;
  logic           samp;
  logic           m_busy;
  logic           s_mid;
  logic           sclk_d;

  wire s_rise   = sclk_s & ~sclk_d;
  wire s_fall   = ~sclk_s & sclk_d;
  wire last_bit = (bcnt == CW'(DW-1));
  wire half_end = (hcnt == HCW'(HALF-1));
  wire [DW-1:0] shifted = {shreg[DW-2:0], samp};

  always_comb begin
    if (!run || !load_req) load_ack = 1'b0;
    else if (is_master)    load_ack = ~m_busy;
    else                   load_ack = (bcnt == '0) & ~s_mid & ~s_rise;
  end

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      shreg   <= '0;
      bcnt    <= '0;
      hcnt    <= '0;
      samp    <= 1'b0;
      m_busy  <= 1'b0;
      s_mid   <= 1'b0;
      sclk_o  <= 1'b0;
      done    <= 1'b0;
      if (rst) rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (load_ack) begin
        shreg <= load_data;
        if (is_master) begin
          m_busy <= 1'b1;
          hcnt   <= '0;
          bcnt   <= '0;
        end
      end
      if (is_master) begin
        s_mid <= 1'b0;
        if (m_busy) begin
          if (half_end) begin
            hcnt   <= '0;
            sclk_o <= ~sclk_o;
            if (!sclk_o) begin
              samp <= miso_s;
            end else begin
              shreg <= shifted;
              bcnt  <= bcnt + 1'b1;
              if (last_bit) begin
                done    <= 1'b1;
                rx_byte <= shifted;
                m_busy  <= 1'b0;
                bcnt    <= '0;
              end
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end else begin
          sclk_o <= 1'b0;
        end
      end else begin
        sclk_o <= 1'b0;
        hcnt   <= '0;
        if (m_busy) begin
          m_busy <= 1'b0;
          bcnt   <= '0;
          s_mid  <= 1'b0;
        end else if (!slv_sel) begin
          bcnt  <= '0;
          s_mid <= 1'b0;
        end else if (s_rise) begin
          samp  <= mosi_s;
          s_mid <= 1'b1;
        end else if (s_fall && s_mid) begin
          s_mid <= 1'b0;
          shreg <= shifted;
          bcnt  <= bcnt + 1'b1;
          if (last_bit) begin
            done    <= 1'b1;
            rx_byte <= shifted;
            bcnt    <= '0;
          end
        end
      end
    end
  end

  assign shift_msb = shreg[DW-1];
endmodule

// File: rtl/spi_csr.sv
module spi_csr
  import spi_flag_pkg::*;
#(
  parameter int DW = BUS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          load_ack,
  input  logic          xfer_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          slave_xfer,
  input  logic          fault_cond,
  output logic [7:0]    ctrl_q,
  output logic [DW-1:0] tx_buf
);
  logic       f_done, f_wcol, f_fault, f_ovr;
  logic [1:0] mode;
  logic       txe, en;
  logic [DW-1:0] rx_buf;
  logic       rx_full;

  wire wr_ctrl = bus_wr & bus_addr;
  wire wr_data = bus_wr & ~bus_addr;

  wire unused_wbit = bus_wdata[B_TXE];

  assign ctrl_q = {f_done, f_wcol, f_fault, f_ovr, mode, txe, en};

  always_ff @(posedge clk) begin
    if (rst) begin
      f_done  <= 1'b0;
      f_wcol  <= 1'b0;
      f_fault <= 1'b0;
      f_ovr   <= 1'b0;
      mode    <= SS_4W_IN;
      txe     <= 1'b1;
      en      <= 1'b0;
      tx_buf  <= '0;
      rx_buf  <= '0;
      rx_full <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        f_done  <= f_done  & bus_wdata[B_DONE];
        f_wcol  <= f_wcol  & bus_wdata[B_WCOL];
        f_fault <= f_fault & bus_wdata[B_FAULT];
        f_ovr   <= f_ovr   & bus_wdata[B_OVR];
        mode    <= bus_wdata[3:2];
        en      <= bus_wdata[B_EN];
      end
      if (wr_data) begin
        if (txe) begin
          tx_buf <= bus_wdata;
          txe    <= 1'b0;
        end else begin
          f_wcol <= 1'b1;
        end
      end
      if (load_ack) txe <= 1'b1;
      if (bus_rd) begin
        bus_rdata <= bus_addr ? ctrl_q : rx_buf;
        if (!bus_addr) rx_full <= 1'b0;
      end
      if (fault_cond) f_fault <= 1'b1;
      if (xfer_done) begin
        f_done <= 1'b1;
        if (slave_xfer && rx_full) begin
          f_ovr <= 1'b1;
        end else begin
          rx_buf  <= rx_byte;
          rx_full <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SCLK_HALF = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             master_req,
  input  logic             irq_enable,
  output logic             irq,
  input  logic             sclk_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  input  logic             mosi_in,
  output logic             mosi_out,
  output logic             mosi_oe,
  input  logic             miso_in,
  output logic             miso_out,
  output logic             miso_oe,
  input  logic             ss_in,
  output logic             ss_out,
  output logic             ss_oe
);
  localparam int NPIN = 4;
  localparam logic [NPIN-1:0] PIN_RST = 4'b1000;

  logic [NPIN-1:0] pins_s;
  logic            ss_s, sclk_s, mosi_s, miso_s;
  logic [7:0]      ctrl_q;
  logic [BUS_W-1:0] tx_buf, rx_byte;
  logic            load_ack, xfer_done, shift_msb, eng_sclk;
  logic            is_master, fault_cond, slv_sel, en;
  logic [1:0]      mode;

  spi_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst(rst),
    .din({ss_in, sclk_in, mosi_in, miso_in}),
    .dout(pins_s)
  );
  assign {ss_s, sclk_s, mosi_s, miso_s} = pins_s;

  assign en   = ctrl_q[B_EN];
  assign mode = ctrl_q[3:2];

  assign is_master  = master_req & en & ~ctrl_q[B_FAULT];
  assign fault_cond = master_req & en & (mode == SS_4W_IN) & ~ss_s;
  assign slv_sel    = (mode == SS_4W_IN) ? ~ss_s : 1'b1;

  spi_csr #(.DW(BUS_W)) u_csr (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .load_ack(load_ack), .xfer_done(xfer_done), .rx_byte(rx_byte),
    .slave_xfer(~is_master), .fault_cond(fault_cond),
    .ctrl_q(ctrl_q), .tx_buf(tx_buf)
  );

  spi_shift_core #(.DW(BUS_W), .HALF(SCLK_HALF)) u_core (
    .clk(clk), .rst(rst), .run(en),
    .is_master(is_master), .slv_sel(slv_sel),
    .sclk_s(sclk_s), .mosi_s(mosi_s), .miso_s(miso_s),
    .load_req(~ctrl_q[B_TXE]), .load_data(tx_buf),
    .load_ack(load_ack), .done(xfer_done), .rx_byte(rx_byte),
    .sclk_o(eng_sclk), .shift_msb(shift_msb)
  );

  assign sclk_out = eng_sclk;
  assign sclk_oe  = is_master;
  assign mosi_out = shift_msb;
  assign mosi_oe  = is_master;
  assign miso_out = shift_msb;
  assign miso_oe  = en & ~is_master & slv_sel;
  assign ss_out   = mode[0];
  assign ss_oe    = en & mode[1];
  assign irq      = irq_enable & (|ctrl_q[7:4]);
endmodule

// File: rtl/spi_flag_ctrl_chk.sv
module spi_flag_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] ctrl_q,
  input logic       irq,
  input logic       irq_enable,
  input logic       sclk_oe,
  input logic       mosi_oe,
  input logic       ss_oe,
  input logic       ss_out
);
  // R3
  a_r3_txe_drops_on_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr && ctrl_q[1]) |=> !ctrl_q[1]);

  // R4
  a_r4_wcol_on_full_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr && !ctrl_q[1]) |=> ctrl_q[6]);

  // R5
  a_r5_fault_releases_bus: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[5] |-> (!sclk_oe && !mosi_oe));

  // R7
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[7] && !(bus_wr && bus_addr && !bus_wdata[7])) |=> ctrl_q[7]);

  // R8
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !irq_enable |-> !irq);

  a_r8_irq_has_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ctrl_q[7:4] != 4'b0));

  // R9
  a_r9_select_drive: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[0] && ctrl_q[3]) |-> (ss_oe && (ss_out == ctrl_q[2])));

  // R11
  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[0] |-> !sclk_oe);
endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .irq(irq),
  .irq_enable(irq_enable), .sclk_oe(sclk_oe), .mosi_oe(mosi_oe),
  .ss_oe(ss_oe), .ss_out(ss_out)
);

// File: tb/spi_flag_ctrl_test.sv
module spi_flag_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic master_req = 1'b0, irq_enable = 1'b0, irq;
  logic sclk_in = 1'b0, sclk_out, sclk_oe;
  logic mosi_in = 1'b0, mosi_out, mosi_oe;
  logic miso_out, miso_oe;
  logic ss_in = 1'b1, ss_out, ss_oe;
  logic loop_en = 1'b0;
  wire  miso_in = loop_en ? mosi_out : 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  bit model_on = 1'b0;
  logic       m_en = 1'b0;
  logic [1:0] m_mode = 2'b01;
  logic [7:0] rv;

  always #4 clk = ~clk;

  spi_flag_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .master_req(master_req), .irq_enable(irq_enable), .irq(irq),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
    .ss_in(ss_in), .ss_out(ss_out), .ss_oe(ss_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (a) begin m_en = d[0]; m_mode = d[3:2]; end
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic slave_send(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mosi_in = b[i];
      tick(8);
      sclk_in = 1'b1;
      tick(8);
      sclk_in = 1'b0;
    end
    tick(10);
  endtask

  // cycle-by-cycle comparison of select and clock drivers against the model
  always @(negedge clk) begin
    if (model_on) begin
      chk(ss_oe == (m_en & m_mode[1]), "R9 ss_oe per-clock", {7'b0, ss_oe}, {7'b0, m_en & m_mode[1]});
      if (ss_oe) chk(ss_out == m_mode[0], "R9 ss_out per-clock", {7'b0, ss_out}, {7'b0, m_mode[0]});
      if (!master_req || !m_en) chk(!sclk_oe, "R11 sclk_oe per-clock", {7'b0, sclk_oe}, 8'h00);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    model_on = 1'b1;

    // R1 reset state
    rd(1'b1, rv); chk(rv == 8'h06, "R1 reset ctrl", rv, 8'h06);
    chk(!irq, "R1 irq low", {7'b0, irq}, 8'h00);
    chk(!sclk_oe, "R1 sclk_oe low", {7'b0, sclk_oe}, 8'h00);

    // R3 buffer fills while disabled, R4 collision drops second byte
    wr(1'b1, 8'h08);
    wr(1'b0, 8'hA5);
    rd(1'b1, rv); chk(rv == 8'h08, "R3 txe cleared", rv, 8'h08);
    wr(1'b0, 8'h3C);
    rd(1'b1, rv); chk(rv == 8'h48, "R4 wcol set", rv, 8'h48);
    irq_enable = 1'b1; #1;
    chk(irq, "R8 irq with flag", {7'b0, irq}, 8'h01);
    irq_enable = 1'b0; #1;
    chk(!irq, "R8 irq gated off", {7'b0, irq}, 8'h00);

    // R2 master loopback, R9 mode 10 drives select low
    master_req = 1'b1; loop_en = 1'b1;
    wr(1'b1, 8'h49);
    chk(ss_oe && !ss_out, "R9 mode10 select", {6'b0, ss_oe, ss_out}, 8'h02);
    tick(150);
    rd(1'b1, rv); chk(rv == 8'hCB, "R2 done after master byte", rv, 8'hCB);
    rd(1'b0, rv); chk(rv == 8'hA5, "R2/R4 received first byte", rv, 8'hA5);

    // R7 clear by zero, keep by one, txe bit ignores writes
    wr(1'b1, 8'hB9);
    rd(1'b1, rv); chk(rv == 8'h8B, "R7 selective clear", rv, 8'h8B);
    irq_enable = 1'b1; #1;
    chk(irq, "R8 irq from done", {7'b0, irq}, 8'h01);
    wr(1'b1, 8'h39);
    rd(1'b1, rv); chk(rv == 8'h0B, "R7 done cleared", rv, 8'h0B);
    chk(!irq, "R8 irq drops", {7'b0, irq}, 8'h00);

    // R6 master overwrite without overrun
    wr(1'b0, 8'h11); tick(150);
    wr(1'b0, 8'h5A); tick(150);
    rd(1'b1, rv); chk(rv == 8'h8B, "R6 no overrun as master", rv, 8'h8B);
    rd(1'b0, rv); chk(rv == 8'h5A, "R6 master overwrite", rv, 8'h5A);

    // R11 abort mid-byte
    wr(1'b0, 8'hC3); tick(20);
    wr(1'b1, 8'h88);
    chk(!sclk_oe, "R11 clock released", {7'b0, sclk_oe}, 8'h00);
    tick(150);
    rd(1'b1, rv); chk(rv == 8'h8A, "R11 flags kept, no done", rv, 8'h8A);

    // R9 mode 11
    wr(1'b1, 8'h0C);
    chk(!ss_oe, "R9 disabled select", {7'b0, ss_oe}, 8'h00);
    wr(1'b1, 8'h0D);
    chk(ss_oe && ss_out, "R9 mode11 select", {6'b0, ss_oe, ss_out}, 8'h03);
    rd(1'b1, rv); chk(rv == 8'h0F, "R9 ctrl mode11", rv, 8'h0F);

    // R5 mode fault
    ss_in = 1'b0;
    wr(1'b1, 8'h05);
    tick(10);
    rd(1'b1, rv); chk(rv == 8'h27, "R5 fault flag", rv, 8'h27);
    chk(!sclk_oe && !mosi_oe, "R5 drivers released", {6'b0, sclk_oe, mosi_oe}, 8'h00);
    chk(irq, "R8 irq from fault", {7'b0, irq}, 8'h01);
    ss_in = 1'b1; tick(5);
    wr(1'b1, 8'h05); tick(5);
    rd(1'b1, rv); chk(rv == 8'h07, "R5 fault cleared", rv, 8'h07);
    master_req = 1'b0; loop_en = 1'b0;

    // R10 three-wire slave, R6 overrun keeps older byte
    wr(1'b1, 8'h01);
    slave_send(8'h96);
    rd(1'b1, rv); chk(rv == 8'h83, "R10 3-wire receive done", rv, 8'h83);
    rd(1'b0, rv); chk(rv == 8'h96, "R10 3-wire byte", rv, 8'h96);
    wr(1'b1, 8'h01);
    slave_send(8'h3C);
    slave_send(8'hE7);
    rd(1'b1, rv); chk(rv == 8'h93, "R6 overrun set", rv, 8'h93);
    rd(1'b0, rv); chk(rv == 8'h3C, "R6 older byte kept", rv, 8'h3C);
    wr(1'b1, 8'h01);

    // R10 four-wire slave honours select
    ss_in = 1'b1;
    wr(1'b1, 8'h05);
    slave_send(8'h55);
    rd(1'b1, rv); chk(rv == 8'h07, "R10 deselected ignored", rv, 8'h07);
    ss_in = 1'b0; tick(10);
    slave_send(8'hE1);
    rd(1'b0, rv); chk(rv == 8'hE1, "R10 selected receive", rv, 8'hE1);

    finished = 1'b1;
    model_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule